// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs memory and I/O read or write transfers on a narrow processor-side bus. On that bus the low address bits and the data share the same lines. The requester places an address, write data, a direction bit and an I/O select on the request port. It holds `req_valid_i` high while `req_ready_o` is high. The block then runs one fixed transfer of three clock periods, named T1, T2 and T3.

In T1 the block puts the low address bits on the shared lines and raises the address-latch strobe, so that an external latch can capture them. In T2 and T3 the shared lines carry data. For a write, the block drives the write data. For a read, the block releases the lines and the target drives them. The active-low read or write strobe frames the data phase. A two-bit status code tells observers which kind of transfer is running. When the transfer ends, the block returns the captured read data together with a one-period completion pulse.

Top module: `mux_bus_seq`

## Requirements
- R1: A request accepted at a clock edge starts T1 in the next period. T2 and T3 follow on the two edges after that, and the block is idle again after T3. Every transfer therefore lasts exactly three periods.
- R2: `io_sel_o` is 1 for an I/O transfer and 0 for a memory transfer, held unchanged through T1, T2 and T3, and 0 when idle. `addr_hi_o` carries address bits [ADDR_W-1:DATA_W] through all three periods and is 0 when idle.
- R3: `ale_o` is 1 only in T1. In T1, `ad_oe_o` is 1, `ad_o` carries address bits [DATA_W-1:0], and both strobes are 1.
- R4: In a read, `rd_n_o` is 0 in T2 and T3. In a write, `wr_n_o` is 0 in T2 and T3. Outside those periods both strobes are 1, and they are never 0 together.
- R5: `stat_o` is 2'b10 during a read, 2'b01 during a write (T1 to T3), and 2'b00 when idle.
- R6: In T2 and T3 of a write, `ad_oe_o` is 1 and `ad_o` carries the write data.
- R7: In T2 and T3 of a read, `ad_oe_o` is 0. The value on `ad_i` at the edge that ends T3 is loaded into `rdata_o`. It is visible from the next period and held until the next read completes. Writes leave it unchanged.
- R8: `done_o` is 1 for exactly the one period that follows T3. `req_ready_o` is 1 only when idle, and 0 in T1 to T3.
- R9: Changes on the request inputs, including a held `req_valid_i`, have no effect on a transfer already in progress.
- R10: While `rst_ni` is 0 the block is idle at once. Both strobes are 1, `stat_o`, `ale_o`, `ad_oe_o` and `done_o` are 0, and `rdata_o` is 0. This holds even when reset arrives in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Transfer address |
| req_wdata_i | input | DATA_W | Write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_ready_o | output | 1 | Idle, request will be taken |
| ale_o | output | 1 | Address latch strobe (T1) |
| io_sel_o | output | 1 | I/O versus memory indicator |
| stat_o | output | 2 | Transfer kind: 10 read, 01 write, 00 idle |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| addr_hi_o | output | ADDR_W-DATA_W | Upper address bits |
| ad_o | output | DATA_W | Shared address/data lines, out |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| ad_i | input | DATA_W | Shared address/data lines, in |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench builds the block with ADDR_W=10 and DATA_W=4. With this configuration every one of the 1024 addresses can be run in all four combinations of direction and address space. Every split of the address between the shared lines and `addr_hi_o` is then checked in each period. During each transfer the bench scrambles the request inputs and holds `req_valid_i` high. It drives `ad_i` with the complement of the expected read value everywhere except T3, so a capture made one edge too early shows up as a wrong `rdata_o`. A final transfer is cut by reset in T2 to check the asynchronous return to idle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } phase_e;

  localparam logic [1:0] ST_IDLE = 2'b00;
  localparam logic [1:0] ST_RD   = 2'b10;
  localparam logic [1:0] ST_WR   = 2'b01;
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic [DATA_W-1:0] ad_i,
  output phase_e            phase_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              write_q_o,
  output logic              io_q_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              ready_o
);
  phase_e phase_q;
  logic   accept;

  assign accept  = (phase_q == PH_IDLE) && req_valid_i;
  assign ready_o = (phase_q == PH_IDLE);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) phase_q <= PH_T1;
        PH_T1:   phase_q <= PH_T2;
        PH_T2:   phase_q <= PH_T3;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // request fields frozen for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      write_q_o <= 1'b0;
      io_q_o    <= 1'b0;
    end else if (accept) begin
      addr_q_o  <= req_addr_i;
      wdata_q_o <= req_wdata_i;
      write_q_o <= req_write_i;
      io_q_o    <= req_io_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= (phase_q == PH_T3);
      if (phase_q == PH_T3 && !write_q_o) rdata_o <= ad_i;
    end
  end

  p_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T1) |-> ##3 done_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T2 || phase_q == PH_T3) |->
      $stable(addr_q_o) && $stable(write_q_o) && $stable(io_q_o));
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  phase_e                   phase_i,
  input  logic [ADDR_W-1:0]        addr_q_i,
  input  logic [DATA_W-1:0]        wdata_q_i,
  input  logic                     write_q_i,
  input  logic                     io_q_i,
  output logic                     ale_o,
  output logic                     io_sel_o,
  output logic [1:0]               stat_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o
);
  logic active, data_ph;

  always_comb begin
    active    = (phase_i != PH_IDLE);
    data_ph   = (phase_i == PH_T2) || (phase_i == PH_T3);
    ale_o     = (phase_i == PH_T1);
    io_sel_o  = active && io_q_i;
    stat_o    = !active ? ST_IDLE : (write_q_i ? ST_WR : ST_RD);
    rd_n_o    = !(data_ph && !write_q_i);
    wr_n_o    = !(data_ph && write_q_i);
    addr_hi_o = active ? addr_q_i[ADDR_W-1:DATA_W] : '0;
    ad_oe_o   = ale_o || (data_ph && write_q_i);
    if (ale_o)                      ad_o = addr_q_i[DATA_W-1:0];
    else if (data_ph && write_q_i)  ad_o = wdata_q_i;
    else                            ad_o = '0;
  end

  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  p_ale_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o && ad_oe_o));
  p_stat_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o != 2'b11));
  p_io_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_o && stat_o != ST_IDLE) |-> ($stable(io_sel_o) && $stable(addr_hi_o)));
  p_read_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic                     req_write_i,
  input  logic                     req_io_i,
  output logic                     req_ready_o,
  output logic                     ale_o,
  output logic                     io_sel_o,
  output logic [1:0]               stat_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  phase_e            phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q, io_q;

  mbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_wdata_i,
    .req_write_i, .req_io_i, .ad_i,
    .phase_o(phase), .addr_q_o(addr_q), .wdata_q_o(wdata_q),
    .write_q_o(write_q), .io_q_o(io_q), .rdata_o, .done_o,
    .ready_o(req_ready_o)
  );

  mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i, .rst_ni, .phase_i(phase), .addr_q_i(addr_q),
    .wdata_q_i(wdata_q), .write_q_i(write_q), .io_q_i(io_q),
    .ale_o, .io_sel_o, .stat_o, .rd_n_o, .wr_n_o,
    .addr_hi_o, .ad_o, .ad_oe_o
  );

  p_hi_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HI_W > 0) && ($countones(stat_o) <= 1));
  p_ready_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (rd_n_o && wr_n_o && !ad_oe_o));
endmodule

// File: tb/tb_mux_bus_seq.sv
`timescale 1ns/1ps
module tb_mux_bus_seq;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int HW = AW - DW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_write, req_io;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, ale, io_sel, rd_n, wr_n, ad_oe, done;
  logic [1:0]    stat;
  logic [HW-1:0] addr_hi;
  logic [DW-1:0] ad_o, ad_in, rdata, cur_rd;
  int            tb_ph;

  int vecs = 0;
  int errs = 0;

  // target drives the true value only in T3, its complement elsewhere
  assign ad_in = (tb_ph == 3) ? cur_rd : ~cur_rd;

  mux_bus_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_write_i(req_write), .req_io_i(req_io),
    .req_ready_o(req_ready), .ale_o(ale), .io_sel_o(io_sel), .stat_o(stat),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .addr_hi_o(addr_hi), .ad_o(ad_o),
    .ad_oe_o(ad_oe), .ad_i(ad_in), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " strobes"}, {rd_n, wr_n}, 2'b11);
    chk({tag, " stat"}, stat, 2'b00);
    chk({tag, " ale/oe"}, {ale, ad_oe}, 2'b00);
    chk({tag, " io/hi"}, {io_sel, addr_hi}, '0);
  endtask

  logic [DW-1:0] last_rd = '0;

  task automatic run_txn(input int a, input bit w, input bit io);
    logic [DW-1:0] wd, rv;
    logic [AW-1:0] av;
    av = AW'(a);
    wd = DW'(a * 7 + int'(w) + 2 * int'(io));
    rv = DW'(a * 5 + 3 + int'(io));
    req_valid = 1'b1; req_addr = av; req_wdata = wd; req_write = w; req_io = io;
    cur_rd = rv; tb_ph = 0;
    @(posedge clk); @(negedge clk); tb_ph = 1;
    chk("R3 ale in T1", ale, 1'b1);
    chk("R3 addr on bus", {ad_oe, ad_o}, {1'b1, av[DW-1:0]});
    chk("R3 strobes idle in T1", {rd_n, wr_n}, 2'b11);
    chk("R2 io in T1", io_sel, io);
    chk("R2 addr_hi in T1", addr_hi, av[AW-1:DW]);
    chk("R5 stat in T1", stat, w ? 2'b01 : 2'b10);
    chk("R8 ready/done in T1", {req_ready, done}, 2'b00);
    // R9: disturb the request port while busy
    req_addr = ~av; req_wdata = ~wd; req_write = ~w; req_io = ~io;
    for (int p = 2; p <= 3; p++) begin
      @(posedge clk); @(negedge clk); tb_ph = p;
      chk("R3 ale low in data phase", ale, 1'b0);
      chk("R9 io held", io_sel, io);
      chk("R9 addr_hi held", addr_hi, av[AW-1:DW]);
      chk("R5 stat in data phase", stat, w ? 2'b01 : 2'b10);
      chk("R4 strobes", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
      chk("R1/R8 busy", {req_ready, done}, 2'b00);
      if (w) chk("R6 write data driven", {ad_oe, ad_o}, {1'b1, wd});
      else   chk("R7 bus released", ad_oe, 1'b0);
      if (p == 3) req_valid = 1'b0;
    end
    @(posedge clk); @(negedge clk); tb_ph = 0;
    chk("R1 R8 done after T3", {done, req_ready}, 2'b11);
    chk_idle("R4 R5 idle after cycle");
    if (!w) last_rd = rv;
    chk("R7 read data", rdata, last_rd);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wdata = '0;
    req_write = 1'b0; req_io = 1'b0; cur_rd = '0; tb_ph = 0;
    repeat (3) @(negedge clk);
    chk_idle("R10 reset");
    chk("R10 reset done/rdata", {done, rdata}, '0);
    chk("R8 ready in reset", req_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < (1 << AW); a++)
        run_txn(a, k[0], k[1]);
    @(negedge clk);
    chk("R8 done single pulse", done, 1'b0);
    // reset in the middle of a write
    req_valid = 1'b1; req_addr = AW'(9); req_wdata = 4'h5; req_write = 1'b1; req_io = 1'b1;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 precondition write strobe", wr_n, 1'b0);
    rst_n = 1'b0; #1;
    chk_idle("R10 mid-cycle reset");
    chk("R10 mid reset done/rdata", {done, rdata}, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R10 stays idle");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule